// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software using a free-running on-chip RC clock. When software fails to restart it for one selectable period, the block raises an interrupt flag. This is a warning stage, meant to let a service routine recover. If that routine does not restart the watchdog within a fixed window, the block issues a reset request pulse of fixed length to the chip's reset controller. It also records that the most recent reset came from the watchdog.

The control inputs come from a CPU register file running on another clock:

- interrupt enable
- reset enable
- 2-bit period select
- a restart input that signals on each change of level

All four pass through a multi-flop synchronizer into the RC domain. A new period select that arrives while the first stage is still counting restarts that count with the new period. Once the interrupt flag is up, the select is frozen until the watchdog is restarted or fires. A watchdog reset returns the internal state to its default, as a system reset does.

Top module: `wdt_two_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, the interrupt flag, `irq`, `rst_req` and `wd_rst_flag` are cleared, and the active period returns to select 00. With select 00 held, the flag rises exactly 2^BASE_LOG2 cycles after release (default 4096), whatever select was active before.
- R2: The active period for select value k (0 to 3) is 2^(BASE_LOG2 + k*STEP_LOG2) cycles. With the defaults this gives 2^12, 2^15, 2^18 and 2^21. A nonzero select present during reset takes effect SYNC_STAGES+1 cycles after release, so the flag rises that many cycles plus the period after release.
- R3: `int_flag` sets at timeout whatever the value of `int_en`. `irq` is high only while both the flag and the synchronized enable are high.
- R4: With `rst_en` set and no restart, `rst_req` rises exactly 2^WIN_LOG2 cycles after `int_flag` rises (default 512).
- R5: `rst_req` stays high for exactly PULSE_CYCLES cycles (default 4). It sets `wd_rst_flag`, which holds until the next `rst_n` assertion.
- R6: With `rst_en` clear, the window can expire and no reset request is issued. `int_flag` stays set until a restart.
- R7: Each level change on `kick_toggle` clears the period counter, the window counter and the interrupt flag. The clear happens at the (SYNC_STAGES+1)th edge after the change, and a full period is then counted from there. The toggle input must be low while `rst_n` is low.
- R8: A changed period select seen while the flag is clear reloads the period and restarts the count. The reload happens at the (SYNC_STAGES+1)th edge after the change.
- R9: Changes to the period select while `int_flag` is set are ignored, and the reset window keeps its length.
- R10: A watchdog reset clears the flag and both counters. Counting resumes after the pulse, and with select 00 the next flag rises 2^BASE_LOG2 cycles after `rst_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC clock |
| rst_n | input | 1 | System reset, synchronous, active low |
| int_en | input | 1 | Interrupt output enable (CPU domain) |
| rst_en | input | 1 | Reset request enable (CPU domain) |
| period_sel | input | 2 | Interrupt period select (CPU domain) |
| kick_toggle | input | 1 | Restart request: every level change is one restart |
| irq | output | 1 | Interrupt to the interrupt controller |
| int_flag | output | 1 | Watchdog interrupt flag (ungated) |
| rst_req | output | 1 | Reset request pulse |
| wd_rst_flag | output | 1 | Last reset was requested by the watchdog |

## Verification
The bench sweeps all four period selects on a shrunken configuration and checks the exact cycle on which the flag rises. A period register that survives `rst_n` would shift the default timeout by the synchronizer latency. A restart late in the window must suppress the reset request: a design that forgets to clear the window counter would still pulse, or would shorten the next window. A select change after the flag is up must leave the window at 2^WIN_LOG2 cycles, and the pulse must last exactly PULSE_CYCLES. With reset disabled the flag must stay up with no pulse, and `irq` must follow the enable while the flag sets regardless of it.

// File: rtl/wdt_pkg.sv
// Package: shared types and helpers for the two-stage watchdog.
// Assumes the period select is two bits wide; each step multiplies the
// period by 2^STEP_LOG2.
package wdt_pkg;

    typedef logic [1:0] wdt_sel_t;

    // Log2 of the first-stage period for a given select value.
    function automatic int unsigned wdt_period_log2(input int unsigned base_log2,
                                                    input int unsigned step_log2,
                                                    input wdt_sel_t    sel);
        return base_log2 + step_log2 * int'(sel);
    endfunction

endpackage

// File: rtl/wdt_sync.sv
// Module: multi-flop synchronizer for a bus of quasi-static control bits.
// Assumes each bit is independent, or changes rarely enough that skew
// between bits does not matter. Resets to all zeros.
module wdt_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned NSTG = (STAGES < 2) ? 2 : STAGES;

    logic [NSTG-1:0][WIDTH-1:0] stg;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < NSTG; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[NSTG-1];

endmodule

// File: rtl/wdt_timebase.sv
// Module: first stage of the watchdog. It holds the active period select,
// counts RC cycles and sets the interrupt flag when the period expires.
// Assumes its inputs are already synchronous to clk. While the flag is set
// or a reset pulse is running, counting and reloading stop.
module wdt_timebase
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 12,
    parameter int unsigned STEP_LOG2 = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  wdt_sel_t sel_s,
    input  logic     kick,
    input  logic     hold,
    input  logic     fire,
    output logic     int_flag
);
    localparam int unsigned CW = BASE_LOG2 + 3 * STEP_LOG2;

    wdt_sel_t      period_q;
    logic [CW-1:0] cnt;
    logic [CW:0]   lim_w;
    logic [CW-1:0] lim_m1;
    logic          running;
    logic          reload;
    logic          expire;

    // Terminal count of the active period.
    always_comb begin
        lim_w  = (CW+1)'(1) << wdt_period_log2(BASE_LOG2, STEP_LOG2, period_q);
        lim_m1 = lim_w[CW-1:0] - CW'(1);
    end

    assign running = !int_flag && !hold;
    assign reload  = running && (sel_s != period_q);
    assign expire  = running && !reload && (cnt == lim_m1);

    // Active period register: back to default on any reset, else follows the select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (fire) begin
            period_q <= '0;
        end else if (reload) begin
            period_q <= sel_s;
        end
    end

    // Period counter: cleared by restart, reload or watchdog reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (kick || fire || reload) begin
            cnt <= '0;
        end else if (running) begin
            cnt <= (cnt == lim_m1) ? '0 : cnt + CW'(1);
        end
    end

    // Interrupt flag: set at expiry, cleared by restart or watchdog reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_flag <= 1'b0;
        end else if (kick || fire) begin
            int_flag <= 1'b0;
        end else if (expire) begin
            int_flag <= 1'b1;
        end
    end

    // While the flag is up the counter rests at zero.
    assert_idle_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_flag |-> (cnt == '0));

    // The select is frozen while the flag stays up.
    assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag && $past(int_flag)) |-> $stable(period_q));

endmodule

// File: rtl/wdt_window.sv
// Module: second stage of the watchdog. It times the window after the
// interrupt flag rises and generates the fixed-length reset request pulse.
// Assumes int_flag and kick are synchronous to clk, and that kick clears
// the flag in the same edge.
module wdt_window #(
    parameter int unsigned WIN_LOG2     = 9,
    parameter int unsigned PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_flag,
    input  logic kick,
    input  logic rst_en_s,
    output logic fire,
    output logic rst_req
);
    localparam int unsigned PW   = $clog2(PULSE_CYCLES + 1);
    localparam int unsigned LW   = PW + 1;
    localparam logic [WIN_LOG2-1:0] WIN_LAST = '1;

    logic [WIN_LOG2-1:0] win_cnt;
    logic [PW-1:0]       pulse_cnt;
    logic [LW-1:0]       hi_len;

    assign fire    = int_flag && (win_cnt == WIN_LAST) && rst_en_s && !kick && (pulse_cnt == '0);
    assign rst_req = (pulse_cnt != '0);

    // Window counter: runs while the flag is up, saturates at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || kick || !int_flag) begin
            win_cnt <= '0;
        end else if (win_cnt != WIN_LAST) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    // Pulse generator: loads the pulse length on fire and counts down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
        end else if (fire) begin
            pulse_cnt <= PW'(PULSE_CYCLES);
        end else if (pulse_cnt != '0) begin
            pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    // Checker-only: length of the current high run of the reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= '0;
        end else begin
            hi_len <= rst_req ? hi_len + 1'b1 : '0;
        end
    end

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (hi_len == LW'(PULSE_CYCLES)));

    assert_req_after_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(int_flag));

endmodule

// File: rtl/wdt_two_stage.sv
// Module: two-stage watchdog top. It synchronizes the CPU-side controls
// into the RC domain and turns restart toggles into one-cycle strobes. It
// also joins the period stage and the window stage, and keeps the
// watchdog-reset status flag. Assumes kick_toggle is low while rst_n is low.
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_LOG2    = 12,
    parameter int unsigned STEP_LOG2    = 3,
    parameter int unsigned WIN_LOG2     = 9,
    parameter int unsigned PULSE_CYCLES = 4,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk_rc,
    input  logic       rst_n,
    input  logic       int_en,
    input  logic       rst_en,
    input  logic [1:0] period_sel,
    input  logic       kick_toggle,
    output logic       irq,
    output logic       int_flag,
    output logic       rst_req,
    output logic       wd_rst_flag
);
    localparam int unsigned SW = 5;

    logic [SW-1:0] ctl_s;
    logic          ien_s;
    logic          ren_s;
    wdt_sel_t      sel_s;
    logic          kick_s;
    logic          kick_prev;
    logic          kick_pulse;
    logic          fire;

    wdt_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk_rc),
        .rst_n(rst_n),
        .din  ({int_en, rst_en, period_sel, kick_toggle}),
        .dout (ctl_s)
    );

    assign {ien_s, ren_s, sel_s, kick_s} = ctl_s;

    // Edge detector: remembers the last synchronized restart level.
    always_ff @(posedge clk_rc) begin
        if (!rst_n) begin
            kick_prev <= 1'b0;
        end else begin
            kick_prev <= kick_s;
        end
    end

    assign kick_pulse = kick_s ^ kick_prev;

    wdt_timebase #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) tb_i (
        .clk     (clk_rc),
        .rst_n   (rst_n),
        .sel_s   (sel_s),
        .kick    (kick_pulse),
        .hold    (rst_req),
        .fire    (fire),
        .int_flag(int_flag)
    );

    wdt_window #(.WIN_LOG2(WIN_LOG2), .PULSE_CYCLES(PULSE_CYCLES)) win_i (
        .clk     (clk_rc),
        .rst_n   (rst_n),
        .int_flag(int_flag),
        .kick    (kick_pulse),
        .rst_en_s(ren_s),
        .fire    (fire),
        .rst_req (rst_req)
    );

    // Status flag: set by a watchdog reset, cleared only by the system reset.
    always_ff @(posedge clk_rc) begin
        if (!rst_n) begin
            wd_rst_flag <= 1'b0;
        end else if (fire) begin
            wd_rst_flag <= 1'b1;
        end
    end

    assign irq = int_flag && ien_s;

    assert_fire_needs_enable_R6: assert property (@(posedge clk_rc) disable iff (!rst_n)
        $rose(rst_req) |-> $past(ren_s));

    assert_status_on_pulse_R5: assert property (@(posedge clk_rc) disable iff (!rst_n)
        rst_req |-> wd_rst_flag);

    assert_kick_drops_flag_R7: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (kick_pulse && !rst_req) |=> !int_flag);

endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BASE = 4;
    localparam int STEP = 2;
    localparam int WINL = 3;
    localparam int PUL  = 4;
    localparam int SYN  = 2;
    localparam int WIN  = 1 << WINL;
    localparam int WD_CYCLES = 150000;

    logic       clk_rc = 1'b0;
    logic       rst_n = 1'b0;
    logic       int_en = 1'b0;
    logic       rst_en = 1'b0;
    logic [1:0] period_sel = 2'b00;
    logic       kick_toggle = 1'b0;
    logic       irq, int_flag, rst_req, wd_rst_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit seen_req = 0;

    wdt_two_stage #(
        .BASE_LOG2(BASE), .STEP_LOG2(STEP), .WIN_LOG2(WINL),
        .PULSE_CYCLES(PUL), .SYNC_STAGES(SYN)
    ) dut_i (
        .clk_rc(clk_rc), .rst_n(rst_n), .int_en(int_en), .rst_en(rst_en),
        .period_sel(period_sel), .kick_toggle(kick_toggle),
        .irq(irq), .int_flag(int_flag), .rst_req(rst_req), .wd_rst_flag(wd_rst_flag)
    );

    always #(CLK_PERIOD/2) clk_rc = ~clk_rc;

    function automatic int period_of(input int k);
        return 1 << (BASE + STEP * k);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk_rc);
        @(negedge clk_rc);
        if (rst_req === 1'b1) seen_req = 1;
    endtask

    task automatic reset_dut(input logic [1:0] sel, input logic ie, input logic re);
        @(negedge clk_rc);
        rst_n = 1'b0;
        period_sel = sel;
        int_en = ie;
        rst_en = re;
        kick_toggle = 1'b0;
        repeat (3) cycle();
        rst_n = 1'b1;
        seen_req = 0;
    endtask

    task automatic wait_int(output int n);
        n = 0;
        while (int_flag !== 1'b1 && n < 5000) begin
            cycle();
            n++;
        end
    endtask

    initial begin
        int n, m;
        // R1: reset state
        reset_dut(2'd0, 1'b1, 1'b1);
        chk("R1 int_flag", int_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 wd_rst_flag", wd_rst_flag, 0);

        // R2 / R3: sweep every period select
        for (int k = 0; k < 4; k++) begin
            reset_dut(2'(k), 1'b1, 1'b0);
            wait_int(n);
            chk($sformatf("R2 period sel=%0d", k), n,
                (k == 0) ? period_of(0) : period_of(k) + SYN + 1);
            chk("R3 irq with enable", irq, 1);
        end

        // R1: reset returns the period to default after select 3 was active
        reset_dut(2'd3, 1'b0, 1'b0);
        repeat (10) cycle();
        reset_dut(2'd0, 1'b0, 1'b0);
        wait_int(n);
        chk("R1 default period after reset", n, period_of(0));

        // R3: flag without enable, irq gated
        chk("R3 flag set with int_en low", int_flag, 1);
        chk("R3 irq gated off", irq, 0);
        int_en = 1'b1;
        repeat (3) cycle();
        chk("R3 irq after enable", irq, 1);

        // R6: window expires with reset disabled
        seen_req = 0;
        repeat (WIN + PUL + 10) cycle();
        chk("R6 no reset request", int'(seen_req), 0);
        chk("R6 flag held", int_flag, 1);

        // R7: restart clears the flag
        kick_toggle = ~kick_toggle;
        repeat (SYN + 1) cycle();
        chk("R7 restart clears flag", int_flag, 0);

        // R4 / R5 / R10: full path to a reset request
        reset_dut(2'd0, 1'b1, 1'b1);
        wait_int(n);
        chk("R4 first stage", n, period_of(0));
        n = 0;
        while (rst_req !== 1'b1 && n < 1000) begin cycle(); n++; end
        chk("R4 window length", n, WIN);
        chk("R5 status flag set", wd_rst_flag, 1);
        chk("R10 flag cleared by watchdog reset", int_flag, 0);
        m = 0;
        while (rst_req === 1'b1 && m < 1000) begin cycle(); m++; end
        chk("R5 pulse length", m, PUL);
        wait_int(n);
        chk("R10 fresh count after pulse", n, period_of(0));
        chk("R5 status flag holds", wd_rst_flag, 1);
        reset_dut(2'd0, 1'b1, 1'b1);
        chk("R5 status cleared by rst_n", wd_rst_flag, 0);

        // R7: restart during the first stage
        repeat (10) cycle();
        kick_toggle = ~kick_toggle;
        wait_int(n);
        chk("R7 restart in first stage", n, period_of(0) + SYN + 1);

        // R7: restart inside the window prevents the reset
        seen_req = 0;
        cycle();
        kick_toggle = ~kick_toggle;
        repeat (SYN + 1) cycle();
        chk("R7 window restart clears flag", int_flag, 0);
        wait_int(n);
        chk("R7 next timeout after window restart", n + SYN + 1, period_of(0) + SYN + 1);
        chk("R7 no reset request after restart", int'(seen_req), 0);

        // R8: period change before the interrupt restarts the count
        reset_dut(2'd0, 1'b1, 1'b1);
        repeat (5) cycle();
        period_sel = 2'd1;
        wait_int(n);
        chk("R8 reload restarts count", n, period_of(1) + SYN + 1);

        // R9: period change while flagged is ignored
        reset_dut(2'd0, 1'b1, 1'b1);
        wait_int(n);
        period_sel = 2'd2;
        n = 0;
        while (rst_req !== 1'b1 && n < 1000) begin cycle(); n++; end
        chk("R9 window unchanged", n, WIN);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk_rc);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule